// File: doc/BRIEF.md
# FIFO-fed pulse-width modulator

This block drives one pulse-width modulated output. Software pushes duty words into a four-deep queue through a simple register port. A counter runs over a programmable period and is clocked by a selectable, prescaled enable. At each period boundary the block can take a new duty word from the queue. The output is formed by comparing the counter against the active duty word, and it can be passed straight through, inverted or held low.

Each duty word can be held for 1, 2, 4 or 8 periods before the next one is taken. When the queue runs dry, the last word stays in use. A status register reports the queue level and four sticky events, and each event is cleared by writing 1 to its bit. A self-clearing software reset returns the whole block to its defaults.

Top module: `fifo_pwm`

## Requirements
- R1: Registers sit at byte offsets 0x00 (control), 0x04 (status), 0x0C (duty) and 0x10 (period). After reset they read 0x0, 0x8, 0x0 and 0xFFFE.
- R2: One output period lasts period+2 counter steps. The counter starts at 0, and in normal mode the output is high while the counter is below the active duty word.
- R3: A period value of 0xFFFF gives the same period as 0xFFFE, which is 65536 steps.
- R4: Control bits 15:4 hold the divide ratio minus one. The counter steps once every field+1 qualifying ticks.
- R5: Control bits 17:16 select the step source. 0 stops counting, 1 uses every clock, 2 uses tick_fast and 3 uses tick_slow.
- R6: Control bits 19:18 select the output mode. 0 is normal, 1 is inverted, and 2 or 3 hold the output low. The output is also low while the block is disabled.
- R7: Control bits 2:1 set how many periods each duty word is used before the next one is taken. The codes 0, 1, 2 and 3 mean 1, 2, 4 and 8 periods.
- R8: The queue holds 4 words, and status bits 2:0 give its fill level. Setting the enable takes the head word. Later words are taken at period boundaries, and the last word is reused when the queue is empty.
- R9: A duty write while the queue is full is dropped, and it sets status bit 6.
- R10: Status bit 3 sets while the queue is empty, bit 4 sets at each period wrap, and bit 5 sets when a step occurs with the counter equal to the duty word. Each of these bits stays set until it is cleared by writing 1 to it.
- R11: Reading the duty register returns the active word while the block is enabled, and 0 otherwise.
- R12: Writing 1 to control bit 3 flushes the queue and restores every default. Bit 3 reads 1 for a few cycles and then clears itself. Register writes made during that time are ignored.
- R13: A new period value takes effect at the next period wrap, not in the middle of a period.
- R14: Control bit 0 enables the block. Enabling it restarts the counter and the prescaler from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_fast | input | 1 | Step enable for source 2 |
| tick_slow | input | 1 | Slow reference step enable for source 3 |
| wr_en | input | 1 | Register write strobe |
| addr | input | 5 | Register byte offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr, combinational |
| pwm_out | output | 1 | Modulated output |

## Verification
The bench builds the block with its defaults: a 16-bit counter, a 12-bit prescaler field, a queue depth of 4 and a 4-cycle software reset. With a 16-bit counter, the clamped maximum period of 65536 steps fits easily within a single run, so the 0xFFFF case is checked at the exact cycle of its wrap. With a depth of 4, the queue fills after four writes, so the dropped fifth write and the reuse of the last word can both be seen in consecutive periods.

// File: rtl/fifo_pwm.sv
module fifo_pwm #(
  parameter int CNT_W       = 16,
  parameter int PRE_W       = 12,
  parameter int DEPTH       = 4,
  parameter int SRST_CYCLES = 4,
  parameter int ADDR_W      = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_fast,
  input  logic              tick_slow,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              pwm_out
);

  localparam int PTR_W  = $clog2(DEPTH);
  localparam int FILL_W = $clog2(DEPTH + 1);
  localparam int SRW    = $clog2(SRST_CYCLES + 1);
  localparam logic [CNT_W-1:0]  PER_ALL = '1;
  localparam logic [CNT_W-1:0]  PER_MAX = PER_ALL - CNT_W'(1);
  localparam logic [FILL_W-1:0] FULL_LVL = FILL_W'(DEPTH);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_DUTY = ADDR_W'(12);
  localparam logic [ADDR_W-1:0] A_PER  = ADDR_W'(16);

  logic              en;
  logic [1:0]        rpt, csel, omode;
  logic [PRE_W-1:0]  pre, pre_cnt;
  logic [7:0]        lp_bits;
  logic [SRW-1:0]    srst_cnt;
  logic [CNT_W-1:0]  mem [DEPTH];
  logic [PTR_W-1:0]  wp, rp;
  logic [FILL_W-1:0] fill;
  logic [CNT_W-1:0]  period_reg, per_act, act, cnt;
  logic [2:0]        rep_cnt;
  logic              fe, rov, cmp, fwe;
  logic              src_tick;

  wire busy    = srst_cnt != '0;
  wire wr_ctrl = wr_en && !busy && addr == A_CTRL;
  wire wr_stat = wr_en && !busy && addr == A_STAT;
  wire wr_duty = wr_en && !busy && addr == A_DUTY;
  wire wr_per  = wr_en && !busy && addr == A_PER;
  wire sw_clear = wr_ctrl && wdata[3];
  wire start    = wr_ctrl && !wdata[3] && wdata[0] && !en;

  always_comb begin
    case (csel)
      2'd0:    src_tick = 1'b0;
      2'd1:    src_tick = 1'b1;
      2'd2:    src_tick = tick_fast;
      default: src_tick = tick_slow;
    endcase
  end

  wire [CNT_W-1:0] per_eff = (per_act == PER_ALL) ? PER_MAX : per_act;
  wire [CNT_W-1:0] last    = per_eff + CNT_W'(1);
  wire             step    = en && src_tick && (pre_cnt >= pre);
  wire             wrap    = step && cnt == last;
  wire [3:0]       rep_span = 4'd1 << rpt;
  wire             rep_done = {1'b0, rep_cnt} >= rep_span - 4'd1;
  wire             have    = fill != '0;
  wire             full    = fill == FULL_LVL;
  wire             pop     = have && (start || (wrap && rep_done));
  wire             push    = wr_duty && !full;
  wire             below   = cnt < act;
  wire             unused_wbits = &{1'b0, wdata[31:28]};

  always_ff @(posedge clk)
    if (push) mem[wp] <= wdata[CNT_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en <= 1'b0; rpt <= '0; csel <= '0; omode <= '0; pre <= '0; lp_bits <= '0;
      srst_cnt <= '0; wp <= '0; rp <= '0; fill <= '0;
      period_reg <= PER_MAX; per_act <= PER_MAX; act <= '0; cnt <= '0;
      pre_cnt <= '0; rep_cnt <= '0;
      fe <= 1'b1; rov <= 1'b0; cmp <= 1'b0; fwe <= 1'b0;
    end else if (sw_clear) begin
      en <= 1'b0; rpt <= '0; csel <= '0; omode <= '0; pre <= '0; lp_bits <= '0;
      srst_cnt <= SRW'(SRST_CYCLES); wp <= '0; rp <= '0; fill <= '0;
      period_reg <= PER_MAX; per_act <= PER_MAX; act <= '0; cnt <= '0;
      pre_cnt <= '0; rep_cnt <= '0;
      fe <= 1'b1; rov <= 1'b0; cmp <= 1'b0; fwe <= 1'b0;
    end else begin
      if (busy) srst_cnt <= srst_cnt - SRW'(1);
      if (wr_ctrl) begin
        en      <= wdata[0];
        rpt     <= wdata[2:1];
        pre     <= wdata[4 +: PRE_W];
        csel    <= wdata[17:16];
        omode   <= wdata[19:18];
        lp_bits <= wdata[27:20];
      end
      if (wr_per) period_reg <= wdata[CNT_W-1:0];
      if (push) wp <= wp + PTR_W'(1);
      if (pop)  rp <= rp + PTR_W'(1);
      fill <= fill + FILL_W'(push) - FILL_W'(pop);

      if (start) begin
        cnt <= '0; pre_cnt <= '0; rep_cnt <= '0; per_act <= period_reg;
        if (have) act <= mem[rp];
      end else if (!en) begin
        cnt <= '0; pre_cnt <= '0;
      end else if (src_tick) begin
        if (step) begin
          pre_cnt <= '0;
          if (wrap) begin
            cnt <= '0;
            per_act <= period_reg;
            if (rep_done) begin
              rep_cnt <= '0;
              if (have) act <= mem[rp];
            end else begin
              rep_cnt <= rep_cnt + 3'd1;
            end
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end else begin
          pre_cnt <= pre_cnt + PRE_W'(1);
        end
      end

      fe  <= !have || (fe && !(wr_stat && wdata[3]));
      rov <= wrap || (rov && !(wr_stat && wdata[4]));
      cmp <= (step && cnt == act) || (cmp && !(wr_stat && wdata[5]));
      fwe <= (wr_duty && full) || (fwe && !(wr_stat && wdata[6]));
    end
  end

  always_comb begin
    pwm_out = 1'b0;
    if (en) begin
      case (omode)
        2'd0:    pwm_out = below;
        2'd1:    pwm_out = !below;
        default: pwm_out = 1'b0;
      endcase
    end
  end

  always_comb begin
    case (addr)
      A_CTRL:  rdata = busy ? 32'h8 : 32'({lp_bits, omode, csel, pre, 1'b0, rpt, en});
      A_STAT:  rdata = 32'({fwe, cmp, rov, fe, 3'(fill)});
      A_DUTY:  rdata = en ? 32'(act) : 32'h0;
      A_PER:   rdata = 32'(period_reg);
      default: rdata = 32'h0;
    endcase
  end

endmodule

module fifo_pwm_chk #(
  parameter int CNT_W  = 16,
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 5
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        wr_en,
  input logic [ADDR_W-1:0]           addr,
  input logic                        busy,
  input logic                        en,
  input logic [1:0]                  omode,
  input logic                        pwm_out,
  input logic [$clog2(DEPTH+1)-1:0]  fill,
  input logic                        fe,
  input logic                        fwe,
  input logic [CNT_W-1:0]            cnt,
  input logic [CNT_W-1:0]            last
);
  localparam int FW = $clog2(DEPTH + 1);

  assert_fill_limit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= FW'(DEPTH));

  assert_full_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !busy && addr == ADDR_W'(12) && fill == FW'(DEPTH)) |=> fwe);

  assert_quiet_out_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!en || omode[1]) |-> !pwm_out);

  assert_cnt_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> cnt <= last);

  assert_srst_clean_R12: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (fill == '0 && !en));

  assert_empty_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (fill == '0) |=> fe);
endmodule

bind fifo_pwm fifo_pwm_chk #(.CNT_W(CNT_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .busy(busy), .en(en),
  .omode(omode), .pwm_out(pwm_out), .fill(fill), .fe(fe), .fwe(fwe),
  .cnt(cnt), .last(last)
);

// File: tb/sim_fifo_pwm.sv
module sim_fifo_pwm;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_fast = 1'b0;
  logic        tick_slow = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        pwm_out;
  int          tests = 0;
  int          fails = 0;

  fifo_pwm u0 (.clk(clk), .rst_n(rst_n), .tick_fast(tick_fast), .tick_slow(tick_slow),
               .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata), .pwm_out(pwm_out));

  always #4 clk = ~clk;

  initial forever begin
    @(negedge clk); tick_fast = 1'b1;
    @(negedge clk); tick_fast = 1'b0;
  end

  initial forever begin
    repeat (3) @(negedge clk); tick_slow = 1'b1;
    @(negedge clk); tick_slow = 1'b0;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic count_hi(input int n, output int h);
    h = 0;
    for (int i = 0; i < n; i++) begin
      h += int'(pwm_out);
      @(negedge clk);
    end
  endtask

  task automatic sreset();
    wr(5'h00, 32'h8);
    repeat (6) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(5'h00, d); chk("R1 ctrl default", d, 32'h0);
    rd(5'h04, d); chk("R1 status default", d, 32'h8);
    rd(5'h0C, d); chk("R1 duty default", d, 32'h0);
    rd(5'h10, d); chk("R1 period default", d, 32'hFFFE);
    chk("R6 output low after reset", 32'(pwm_out), 32'h0);
  endtask

  task automatic t_basic();
    logic [31:0] d; int h;
    sreset();
    wr(5'h10, 6); wr(5'h0C, 3); wr(5'h0C, 5);
    rd(5'h04, d); chk("R8 fill after two pushes", d & 32'h7, 32'h2);
    wr(5'h00, 32'h10001);
    rd(5'h04, d); chk("R14 enable takes head word", d & 32'h7, 32'h1);
    rd(5'h0C, d); chk("R11 duty readback enabled", d, 32'h3);
    count_hi(8, h); chk("R2 period 8 duty 3", 32'(h), 32'h3);
    count_hi(8, h); chk("R8 second word at boundary", 32'(h), 32'h5);
    rd(5'h04, d); chk("R8 queue drained", d & 32'h7, 32'h0);
    count_hi(8, h); chk("R8 last word reused", 32'(h), 32'h5);
    wr(5'h00, 32'h10000);
    rd(5'h0C, d); chk("R11 duty reads zero disabled", d, 32'h0);
    chk("R6 output low disabled", 32'(pwm_out), 32'h0);
  endtask

  task automatic t_modes();
    int h;
    sreset();
    wr(5'h10, 6); wr(5'h0C, 3); wr(5'h00, 32'h50001);
    count_hi(8, h); chk("R6 inverted mode", 32'(h), 32'h5);
    sreset();
    wr(5'h10, 6); wr(5'h0C, 3); wr(5'h00, 32'h90001);
    count_hi(16, h); chk("R6 forced low mode", 32'(h), 32'h0);
  endtask

  task automatic t_repeat();
    int h;
    sreset();
    wr(5'h10, 6); wr(5'h0C, 2); wr(5'h0C, 6); wr(5'h00, 32'h10003);
    count_hi(8, h); chk("R7 repeat2 p1", 32'(h), 32'h2);
    count_hi(8, h); chk("R7 repeat2 p2", 32'(h), 32'h2);
    count_hi(8, h); chk("R7 repeat2 p3", 32'(h), 32'h6);
    count_hi(8, h); chk("R7 repeat2 p4", 32'(h), 32'h6);
  endtask

  task automatic t_prescale();
    int h;
    sreset();
    wr(5'h10, 6); wr(5'h0C, 3); wr(5'h00, 32'h10011);
    count_hi(16, h); chk("R4 divide by 2 p1", 32'(h), 32'h6);
    count_hi(16, h); chk("R4 divide by 2 p2", 32'(h), 32'h6);
  endtask

  task automatic t_clksel();
    logic [31:0] d; int h;
    sreset();
    wr(5'h10, 6); wr(5'h0C, 3); wr(5'h00, 32'h00001);
    count_hi(20, h); chk("R5 source off holds counter", 32'(h), 32'd20);
    rd(5'h04, d); chk("R5 no wrap with source off", d & 32'h10, 32'h0);
    sreset();
    wr(5'h10, 6); wr(5'h0C, 3); wr(5'h00, 32'h20001);
    repeat (40) @(negedge clk);
    count_hi(48, h); chk("R5 tick_fast source", 32'(h), 32'd18);
    sreset();
    wr(5'h10, 6); wr(5'h0C, 3); wr(5'h00, 32'h30001);
    repeat (40) @(negedge clk);
    count_hi(64, h); chk("R5 tick_slow source", 32'(h), 32'd24);
  endtask

  task automatic t_full();
    logic [31:0] d; int h;
    sreset();
    wr(5'h10, 6);
    for (int i = 1; i <= 5; i++) wr(5'h0C, 32'(i));
    rd(5'h04, d); chk("R9 full status with error", d, 32'h4C);
    wr(5'h04, 32'h48);
    rd(5'h04, d); chk("R10 write one clears", d, 32'h04);
    wr(5'h00, 32'h10001);
    for (int i = 1; i <= 4; i++) begin
      count_hi(8, h); chk("R9 queued word order", 32'(h), 32'(i));
    end
    count_hi(8, h); chk("R9 fifth word dropped", 32'(h), 32'h4);
    rd(5'h04, d); chk("R10 wrap and compare flags", d & 32'h38, 32'h38);
  endtask

  task automatic t_max_period();
    logic [31:0] d;
    sreset();
    wr(5'h10, 32'hFFFF); wr(5'h0C, 32'h8000);
    rd(5'h10, d); chk("R1 period readback", d, 32'hFFFF);
    wr(5'h00, 32'h10001);
    repeat (65535) @(negedge clk);
    rd(5'h04, d); chk("R3 no wrap before 65536", d & 32'h10, 32'h0);
    @(negedge clk);
    rd(5'h04, d); chk("R3 wrap at 65536", d & 32'h10, 32'h10);
  endtask

  task automatic t_period_update();
    int h0, h1;
    sreset();
    wr(5'h10, 6); wr(5'h0C, 2); wr(5'h00, 32'h10001);
    h0 = 0; h1 = 0;
    for (int i = 0; i < 20; i++) begin
      if (i < 8) h0 += int'(pwm_out); else h1 += int'(pwm_out);
      if (i == 2) begin wr_en = 1'b1; addr = 5'h10; wdata = 32'h2; end
      if (i == 3) wr_en = 1'b0;
      @(negedge clk);
    end
    chk("R13 current period kept", 32'(h0), 32'h2);
    chk("R13 new period after wrap", 32'(h1), 32'h6);
  endtask

  task automatic t_sreset();
    logic [31:0] d;
    sreset();
    wr(5'h10, 6); wr(5'h0C, 3); wr(5'h0C, 4); wr(5'h00, 32'h10001);
    repeat (3) @(negedge clk);
    wr(5'h00, 32'h8);
    wr(5'h10, 5);
    rd(5'h00, d); chk("R12 reset bit reads one", d, 32'h8);
    repeat (5) @(negedge clk);
    rd(5'h00, d); chk("R12 reset bit self clears", d, 32'h0);
    rd(5'h04, d); chk("R12 queue flushed", d, 32'h8);
    rd(5'h10, d); chk("R12 period default, busy write ignored", d, 32'hFFFE);
    chk("R12 output low", 32'(pwm_out), 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_modes();
    t_repeat();
    t_prescale();
    t_clksel();
    t_full();
    t_period_update();
    t_sreset();
    t_max_period();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule